// File: doc/BRIEF.md
# Burst transmit timing sequencer

This block times one transmit burst of a differential-phase modulator. It runs on a fast clock that is four times the symbol-half rate (one SINT period is four clock cycles), so every interval is counted in quarter-SINT steps. A free-running tick counter marks one cycle in four as the SINT strobe. On that strobe the block samples the host's burst-enable bit. The edges of the sampled bit open and close the burst.

While the burst is open, the block takes one bit per SINT from a host-written data word, least significant bit first, and pairs the bits into dibits. It drives the power-amplifier enable and emits single-cycle strobes for the following events: ramp-up start, first peak-symbol point, last peak-symbol point, ramp-down start and outputs-at-zero. The ramp, the filter flush and the decay are modelled only as counted intervals.

A 2-bit offset d delays the whole envelope, amplifier enable included, by d clock cycles (quarter-SINT steps). The offset is captured at burst start. Delays of a full SINT or more are left to the host, which writes the enable and the data later.

Top module: `bts_burst_seq`

## Requirements
- R1: The SINT strobe falls in every clock cycle whose index since reset release is 3 modulo 4, counting the first cycle after release as 0. `burst_en` is sampled only in those cycles.
- R2: Take a strobe cycle k that samples `burst_en` high and starts a burst. `ramp_up_stb` pulses for one cycle in cycle k+2+d, and `pa_en` goes high in the same cycle.
- R3: `first_pk_stb` pulses 24 cycles (6 SINT) after `ramp_up_stb`.
- R4: Take the strobe cycle f that first samples `burst_en` low during a burst. `last_pk_stb` and `ramp_dn_stb` pulse together in cycle f+54+d. That point is 13.5 SINT after f, which is 15.5 SINT after the symbol taken two SINT earlier.
- R5: `zero_stb` pulses 24 cycles after `last_pk_stb`, and `pa_en` is low from that cycle on. `pa_en` stays high without a break from the ramp-up strobe until then.
- R6: The offset `off_cfg` is captured in the strobe cycle that starts the burst. Any change to it during the burst has no effect on that burst's timing.
- R7: Every offset value d from 0 to 3 shifts all five strobes and both `pa_en` edges by exactly d cycles. Their relative spacing is unchanged.
- R8: On every strobe cycle in which the sampled enable is already high, bit 0 of the data register is taken and the register shifts right with a zero entering at the top. A `tx_wr` in the same cycle loads `tx_wdata` instead of the shift, but the bit taken is still the old bit 0.
- R9: Bits are paired in the order taken. `dibit[0]` is the earlier bit and `dibit[1]` the later one. `dibit_vld` pulses for one cycle, in the cycle after the strobe that takes the second bit. Pairing restarts at each burst start, and an unpaired final bit is dropped.
- R10: A strobe that samples `burst_en` high while `pa_en` is still high after the previous burst's enable went low does not start a burst. The next burst starts at the first strobe that finds `pa_en` low.
- R11: While `rst` is high, `pa_en`, all strobes and `dibit_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four cycles per SINT |
| rst | input | 1 | Synchronous active-high reset |
| burst_en | input | 1 | Host burst request, sampled on SINT strobes |
| off_cfg | input | $clog2(QPS) | Quarter-SINT envelope offset d |
| tx_wr | input | 1 | Load strobe for the data register |
| tx_wdata | input | DATA_W | Data word, sent LSB first |
| pa_en | output | 1 | Power-amplifier enable |
| ramp_up_stb | output | 1 | Ramp-up start pulse |
| first_pk_stb | output | 1 | First peak-symbol point pulse |
| last_pk_stb | output | 1 | Last peak-symbol point pulse |
| ramp_dn_stb | output | 1 | Ramp-down start pulse |
| zero_stb | output | 1 | Outputs-at-zero pulse |
| dibit | output | 2 | Last completed bit pair |
| dibit_vld | output | 1 | One-cycle pulse marking a new dibit |

## Verification
The bench builds the block with DATA_W set to 8 and keeps the defaults for the tick ratio, ramp length and flush length. The default timing parameters keep the 6-SINT ramp and the 13.5-SINT flush exact. The narrow word empties after four dibits, so a single burst covers zero fill, reloads in mid-burst and a write that lands on a shift strobe. The stimulus also covers all four offsets, an offset change inside a burst, a one-SINT burst with an odd leftover bit, and a request raised during the flush.

// File: rtl/bts_pkg.sv
package bts_pkg;
  typedef logic [1:0] dibit_t;

  typedef struct packed {
    logic ramp_up;
    logic first_pk;
    logic last_pk;
    logic ramp_dn;
    logic at_zero;
  } env_strb_t;
endpackage

// File: rtl/bts_sint_gen.sv
module bts_sint_gen #(
  parameter int QPS = 4
) (
  input  logic clk,
  input  logic rst,
  output logic sint_stb
);
  localparam int CW = (QPS > 1) ? $clog2(QPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(QPS - 1);

  logic [CW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (rst) tcnt <= '0;
    else if (tcnt == LAST) tcnt <= '0;
    else tcnt <= tcnt + 1'b1;
  end

  assign sint_stb = (tcnt == LAST);

  // R1: strobes are never adjacent
  a_r1_stb_gap: assert property (@(posedge clk) disable iff (rst)
    sint_stb |=> !sint_stb);
endmodule

// File: rtl/bts_env_sampler.sv
module bts_env_sampler #(
  parameter int QPS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sint_stb,
  input  logic                     burst_en,
  input  logic [$clog2(QPS)-1:0]   off_cfg,
  input  logic                     pa_busy,
  output logic                     en_s,
  output logic                     en_d,
  output logic                     start
);
  localparam int OW = $clog2(QPS);

  logic [OW-1:0]  off_q;
  logic [QPS-1:0] dline;
  logic           en_nx;

  // a new burst may only open once the envelope has fully closed
  assign en_nx = burst_en & (en_s | ~pa_busy);
  assign start = sint_stb & ~en_s & en_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_s  <= 1'b0;
      off_q <= '0;
    end else if (sint_stb) begin
      en_s <= en_nx;
      if (!en_s && en_nx) off_q <= off_cfg;
    end
  end

  assign dline[0] = en_s;
  for (genvar i = 1; i < QPS; i++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) dline[i] <= 1'b0;
      else dline[i] <= dline[i-1];
    end
  end

  assign en_d = dline[off_q];

  // R6: offset frozen while a burst is open
  a_r6_off_hold: assert property (@(posedge clk) disable iff (rst)
    (en_s && $past(en_s)) |-> $stable(off_q));
  // R10: sampled enable only rises when the envelope is closed
  a_r10_start_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(en_s) |-> !$past(pa_busy));
endmodule

// File: rtl/bts_dibit_shifter.sv
module bts_dibit_shifter
  import bts_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sint_stb,
  input  logic              en_s,
  input  logic              start,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_wdata,
  output dibit_t            dibit,
  output logic              dibit_vld
);
  logic [DATA_W-1:0] sr;
  logic              phase;
  logic              lo_bit;
  logic              take;

  assign take = sint_stb & en_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr        <= '0;
      phase     <= 1'b0;
      lo_bit    <= 1'b0;
      dibit     <= '0;
      dibit_vld <= 1'b0;
    end else begin
      dibit_vld <= 1'b0;
      if (tx_wr) sr <= tx_wdata;
      else if (take) sr <= sr >> 1;
      if (start) begin
        phase <= 1'b0;
      end else if (take) begin
        if (!phase) begin
          lo_bit <= sr[0];
          phase  <= 1'b1;
        end else begin
          dibit     <= {sr[0], lo_bit};
          dibit_vld <= 1'b1;
          phase     <= 1'b0;
        end
      end
    end
  end

  // R9: a dibit is a single-cycle pulse
  a_r9_vld_pulse: assert property (@(posedge clk) disable iff (rst)
    dibit_vld |=> !dibit_vld);
  // R8: bits are only taken inside a burst
  a_r8_vld_in_burst: assert property (@(posedge clk) disable iff (rst)
    dibit_vld |-> $past(en_s));
endmodule

// File: rtl/bts_envelope_timer.sv
module bts_envelope_timer
  import bts_pkg::*;
#(
  parameter int RAMP_Q  = 24,
  parameter int FLUSH_Q = 54
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      en_d,
  output logic      pa_en,
  output env_strb_t strb
);
  // the counter starts two cycles after the sampling strobe, and a registered
  // strobe adds one more cycle, so three cycles come off the flush threshold
  localparam int UP_W  = $clog2(RAMP_Q + 1);
  localparam int DN_W  = $clog2(FLUSH_Q + RAMP_Q + 1);
  localparam int FP_AT = RAMP_Q - 1;
  localparam int LP_AT = FLUSH_Q - 3;
  localparam int Z_AT  = FLUSH_Q + RAMP_Q - 3;

  logic            en_d_q;
  logic            rise, fall;
  logic [UP_W-1:0] up_cnt;
  logic            up_run;
  logic [DN_W-1:0] dn_cnt;
  logic            dn_run;

  assign rise = en_d & ~en_d_q;
  assign fall = ~en_d & en_d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d_q <= 1'b0;
      pa_en  <= 1'b0;
      strb   <= '0;
      up_cnt <= '0;
      up_run <= 1'b0;
      dn_cnt <= '0;
      dn_run <= 1'b0;
    end else begin
      en_d_q <= en_d;
      strb   <= '0;
      if (rise) begin
        pa_en        <= 1'b1;
        strb.ramp_up <= 1'b1;
        up_cnt       <= '0;
        up_run       <= 1'b1;
      end else if (up_run) begin
        if (up_cnt == UP_W'(FP_AT)) begin
          strb.first_pk <= 1'b1;
          up_run        <= 1'b0;
        end else begin
          up_cnt <= up_cnt + 1'b1;
        end
      end
      if (fall) begin
        dn_cnt <= '0;
        dn_run <= 1'b1;
      end else if (dn_run) begin
        if (dn_cnt == DN_W'(LP_AT)) begin
          strb.last_pk <= 1'b1;
          strb.ramp_dn <= 1'b1;
        end
        if (dn_cnt == DN_W'(Z_AT)) begin
          strb.at_zero <= 1'b1;
          pa_en        <= 1'b0;
          dn_run       <= 1'b0;
        end
        dn_cnt <= dn_cnt + 1'b1;
      end
    end
  end

  // R2: enable rises together with the ramp strobe
  a_r2_pa_with_ramp: assert property (@(posedge clk) disable iff (rst)
    $rose(pa_en) |-> strb.ramp_up);
  // R3: the first peak falls inside the enable window
  a_r3_fpk_in_window: assert property (@(posedge clk) disable iff (rst)
    strb.first_pk |-> pa_en);
  // R4: the last peak falls inside the enable window
  a_r4_lpk_in_window: assert property (@(posedge clk) disable iff (rst)
    strb.last_pk |-> pa_en);
  // R5: the zero point is the cycle the enable drops
  a_r5_zero_drops_pa: assert property (@(posedge clk) disable iff (rst)
    strb.at_zero |-> (!pa_en && $past(pa_en)));
endmodule

// File: rtl/bts_burst_seq.sv
module bts_burst_seq
  import bts_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int QPS     = 4,
  parameter int RAMP_Q  = 24,
  parameter int FLUSH_Q = 54
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   burst_en,
  input  logic [$clog2(QPS)-1:0] off_cfg,
  input  logic                   tx_wr,
  input  logic [DATA_W-1:0]      tx_wdata,
  output logic                   pa_en,
  output logic                   ramp_up_stb,
  output logic                   first_pk_stb,
  output logic                   last_pk_stb,
  output logic                   ramp_dn_stb,
  output logic                   zero_stb,
  output logic [1:0]             dibit,
  output logic                   dibit_vld
);
  logic      sint_stb;
  logic      en_s, en_d, start;
  logic      pa_i;
  env_strb_t strb;
  dibit_t    dibit_i;

  bts_sint_gen #(.QPS(QPS)) u_sint (
    .clk(clk), .rst(rst), .sint_stb(sint_stb)
  );

  bts_env_sampler #(.QPS(QPS)) u_samp (
    .clk(clk), .rst(rst), .sint_stb(sint_stb), .burst_en(burst_en),
    .off_cfg(off_cfg), .pa_busy(pa_i), .en_s(en_s), .en_d(en_d),
    .start(start)
  );

  bts_dibit_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .sint_stb(sint_stb), .en_s(en_s), .start(start),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .dibit(dibit_i), .dibit_vld(dibit_vld)
  );

  bts_envelope_timer #(.RAMP_Q(RAMP_Q), .FLUSH_Q(FLUSH_Q)) u_env (
    .clk(clk), .rst(rst), .en_d(en_d), .pa_en(pa_i), .strb(strb)
  );

  assign pa_en        = pa_i;
  assign ramp_up_stb  = strb.ramp_up;
  assign first_pk_stb = strb.first_pk;
  assign last_pk_stb  = strb.last_pk;
  assign ramp_dn_stb  = strb.ramp_dn;
  assign zero_stb     = strb.at_zero;
  assign dibit        = dibit_i;
endmodule

// File: tb/sim_bts_burst_seq.sv
module sim_bts_burst_seq;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          burst_en = 1'b0;
  logic [1:0]    off_cfg = 2'd0;
  logic          tx_wr = 1'b0;
  logic [DW-1:0] tx_wdata = '0;
  logic          pa_en, ramp_up_stb, first_pk_stb, last_pk_stb;
  logic          ramp_dn_stb, zero_stb, dibit_vld;
  logic [1:0]    dibit;

  bts_burst_seq #(.DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .burst_en(burst_en), .off_cfg(off_cfg),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .pa_en(pa_en),
    .ramp_up_stb(ramp_up_stb), .first_pk_stb(first_pk_stb),
    .last_pk_stb(last_pk_stb), .ramp_dn_stb(ramp_dn_stb),
    .zero_stb(zero_stb), .dibit(dibit), .dibit_vld(dibit_vld)
  );

  always #10 clk = ~clk;

  int    vectors = 0;
  int    fails = 0;
  string scen = "R11 reset";

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s]: got %0d expected %0d", what, scen, act, exp);
    end
  endtask

  // behavioural reference: event times scheduled from each sampled edge
  int            cyc = 0;
  bit            m_en_s = 0;
  int            m_d = 0;
  int            t_ramp = -100, t_fpk = -100, t_lpk = -100, t_zero = -100;
  int            t_on = -100, t_off = -100, t_dib = -100;
  logic [1:0]    exp_dib = '0;
  logic [DW-1:0] m_word = '0;
  bit            m_phase = 0, m_lo = 0;

  function automatic bit pa_at(input int c);
    return (c >= t_on) && (c < t_off);
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      bit pa_x, idle, nx, b;
      pa_x = pa_at(cyc);
      chk(ramp_up_stb === (cyc == t_ramp), "R2 ramp_up (R1 sampling)", int'(ramp_up_stb), int'(cyc == t_ramp));
      chk(first_pk_stb === (cyc == t_fpk), "R3 first_pk", int'(first_pk_stb), int'(cyc == t_fpk));
      chk(last_pk_stb === (cyc == t_lpk), "R4 last_pk", int'(last_pk_stb), int'(cyc == t_lpk));
      chk(ramp_dn_stb === (cyc == t_lpk), "R4 ramp_dn", int'(ramp_dn_stb), int'(cyc == t_lpk));
      chk(zero_stb === (cyc == t_zero), "R5 zero", int'(zero_stb), int'(cyc == t_zero));
      chk(pa_en === pa_x, "R5 pa_en", int'(pa_en), int'(pa_x));
      chk(dibit_vld === (cyc == t_dib), "R9 dibit_vld", int'(dibit_vld), int'(cyc == t_dib));
      if (cyc == t_dib)
        chk(dibit === exp_dib, "R8 dibit value", int'(dibit), int'(exp_dib));
      if (cyc % 4 == 3) begin
        idle = !pa_x && !m_en_s;
        nx = burst_en && (m_en_s || idle);
        if (m_en_s) begin
          b = m_word[0];
          if (!m_phase) begin
            m_lo = b; m_phase = 1;
          end else begin
            exp_dib = {b, m_lo}; t_dib = cyc + 1; m_phase = 0;
          end
          if (!tx_wr) m_word = m_word >> 1;
        end
        if (!m_en_s && nx) begin
          m_d = int'(off_cfg);
          t_ramp = cyc + 2 + m_d; t_on = t_ramp; t_off = 1 << 30;
          t_fpk = t_ramp + 24; m_phase = 0;
        end
        if (m_en_s && !nx) begin
          t_lpk = cyc + 54 + m_d; t_zero = t_lpk + 24; t_off = t_zero;
        end
        m_en_s = nx;
      end
      if (tx_wr) m_word = tx_wdata;
      cyc++;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic wr(input logic [DW-1:0] w);
    tx_wr = 1'b1; tx_wdata = w;
    step(1);
    tx_wr = 1'b0;
  endtask

  task automatic burst(input int d, input int len);
    off_cfg = 2'(d);
    burst_en = 1'b1;
    step(len);
    burst_en = 1'b0;
    step(110);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 20000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    step(3);
    @(negedge clk);
    // R11: quiet outputs under reset
    chk({pa_en, ramp_up_stb, first_pk_stb, last_pk_stb, ramp_dn_stb, zero_stb, dibit_vld} === 7'd0,
        "R11 reset outputs", int'({pa_en, ramp_up_stb, zero_stb, dibit_vld}), 0);
    @(posedge clk);
    #2 rst = 1'b0;
    step(2);

    scen = "R2 R3 R4 R5 R8 R9 basic";
    wr(8'b1011_0010);
    burst(0, 29);

    scen = "R7 offset sweep";
    for (int d = 1; d < 4; d++) begin
      wr(8'(8'h5A + d));
      burst(d, 17 + d);
    end

    scen = "R6 offset change inside burst";
    wr(8'hC3);
    off_cfg = 2'd2; burst_en = 1'b1;
    step(9);
    off_cfg = 2'd0;
    step(12);
    off_cfg = 2'd3;
    step(6);
    burst_en = 1'b0;
    step(110);

    scen = "R10 request during flush";
    wr(8'hE7);
    off_cfg = 2'd1; burst_en = 1'b1;
    step(48);
    burst_en = 1'b0;
    step(9);
    burst_en = 1'b1;
    off_cfg = 2'd3;
    step(140);
    burst_en = 1'b0;
    step(110);

    scen = "R8 writes during burst and zero fill";
    wr(8'h96);
    off_cfg = 2'd3; burst_en = 1'b1;
    step(10);
    wr(8'h3C);
    step(2);
    wr(8'hA5);
    step(60);
    burst_en = 1'b0;
    step(110);

    scen = "R9 single-SINT burst";
    wr(8'hFF);
    burst(2, 4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule